// File: doc/BRIEF.md
# Saturating Performance Event Counter

This block counts single-cycle error or event pulses for a performance monitor. The count never wraps. When it reaches its all-ones value it stays there until the next update-clear. An update-clear strobe copies the live count into a holding register, where software can read it at leisure. The same strobe restarts the live count. If an event lands in the same cycle as the update-clear, the count restarts at one, so that event is kept for the next interval.

Three status outputs go with the count:
- A level flag that is high while the live count is nonzero.
- A sticky flag that records the count leaving zero.
- A sticky flag that records every event seen.

Each sticky flag has its own write-one-to-clear input.

The live counter is controlled by a three-state machine:
- `ST_ZERO`: the count is zero.
- `ST_COUNT`: the count is between one and one below the maximum.
- `ST_FULL`: the count is saturated.

The transitions are:
- `ST_ZERO -> ST_COUNT` on an event, or on an update-clear that has an event with it.
- `ST_COUNT -> ST_COUNT` on an event below maximum minus one, or on an update-clear with an event.
- `ST_COUNT -> ST_FULL` on an event when the count equals maximum minus one.
- `ST_COUNT -> ST_ZERO` on an update-clear without an event.
- `ST_FULL -> ST_FULL` on an event, with no count change.
- `ST_FULL -> ST_COUNT` on an update-clear with an event.
- `ST_FULL -> ST_ZERO` on an update-clear without an event.

An update-clear overrides every other transition.

Set `CNT_W` (at least 2) so that one second of events at the fastest event rate fits below saturation.

Top module: `perf_evt_counter`

## Requirements
- R1: The live count stops at 2^CNT_W-1. An event while it is there leaves the count unchanged.
- R2: Without an update-clear, each cycle with `evt_i` high raises the live count by one, one clock later, unless the count is saturated. A cycle without an event leaves the count unchanged.
- R3: `nonzero_o` is high exactly when `live_o` is nonzero.
- R4: `first_latch_o` is set one clock after an event that arrives while the live count is zero, or in the same cycle as an update-clear.
- R5: `evt_latch_o` is set one clock after every event, including events that arrive while the count is saturated.
- R6: An update-clear happens in the first cycle in which `upd_i` is seen high after being low. In that cycle, `hold_o` takes the live count and the live count returns to zero. Holding `upd_i` high does not cause another transfer.
- R7: An event in the update-clear cycle makes the live count one, not zero.
- R8: After reset, `hold_o`, `live_o` and every flag are zero. Between update-clears, `hold_o` keeps its value.
- R9: A one on `clr_first_i` or `clr_evt_i` clears the matching sticky flag on the next clock. If the flag's set condition occurs in the same cycle, the set takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 1 | Event pulse, one event per high cycle |
| upd_i | input | 1 | Update-clear request; acts on its rising edge |
| clr_first_i | input | 1 | Write-one-to-clear for the zero-to-one flag |
| clr_evt_i | input | 1 | Write-one-to-clear for the per-event flag |
| hold_o | output | CNT_W | Count captured at the last update-clear |
| live_o | output | CNT_W | Running count |
| nonzero_o | output | 1 | High while the running count is nonzero |
| first_latch_o | output | 1 | Sticky: count left zero |
| evt_latch_o | output | 1 | Sticky: an event occurred |

## Verification
The assertions check on every cycle that:
- a count at maximum stays there and a count below it moves up by one per event;
- the nonzero flag agrees with the count;
- the holding register loads the live count on an update-clear and is stable otherwise;
- an event in the update-clear cycle leaves a count of one;
- both sticky flags follow their set and clear rules.

Only the bench scenarios can show the following:
- one transfer per held update level;
- the values visible after reset;
- the full run up to saturation with a captured all-ones value;
- a set and a clear arriving together.

// File: rtl/pec_pkg.sv
package pec_pkg;
    typedef enum logic [1:0] {
        ST_ZERO  = 2'd0,
        ST_COUNT = 2'd1,
        ST_FULL  = 2'd2
    } cnt_state_e;

    localparam int FLAG_FIRST = 0;
    localparam int FLAG_EVT   = 1;
    localparam int NUM_FLAGS  = 2;
endpackage

// File: rtl/pec_upd_edge.sv
module pec_upd_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic upd_i,
    output logic upd_pulse_o
);
    logic upd_q;

    always_ff @(posedge clk) begin
        if (!rst_n) upd_q <= 1'b0;
        else        upd_q <= upd_i;
    end

    assign upd_pulse_o = upd_i & ~upd_q;
endmodule

// File: rtl/pec_count_core.sv
module pec_count_core
    import pec_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_i,
    input  logic             upd_pulse_i,
    output logic [CNT_W-1:0] live_o,
    output logic             nonzero_o,
    output logic             first_evt_o
);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_EDGE = CNT_MAX - CNT_ONE;

    cnt_state_e       state_q, state_n;
    logic [CNT_W-1:0] live_q, live_n;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ZERO;
            live_q  <= '0;
        end else begin
            state_q <= state_n;
            live_q  <= live_n;
        end
    end

    // next state; update-clear overrides every other transition
    always_comb begin
        state_n = state_q;
        live_n  = live_q;
        if (upd_pulse_i) begin
            live_n  = evt_i ? CNT_ONE : '0;
            state_n = evt_i ? ST_COUNT : ST_ZERO;
        end else begin
            unique case (state_q)
                ST_ZERO: begin
                    if (evt_i) begin
                        live_n  = CNT_ONE;
                        state_n = ST_COUNT;
                    end
                end
                ST_COUNT: begin
                    if (evt_i) begin
                        live_n = live_q + CNT_ONE;
                        if (live_q == CNT_EDGE) state_n = ST_FULL;
                    end
                end
                ST_FULL: begin
                    state_n = ST_FULL;
                end
                default: begin
                    state_n = ST_ZERO;
                    live_n  = '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        live_o      = live_q;
        nonzero_o   = (state_q != ST_ZERO);
        first_evt_o = evt_i & (upd_pulse_i | (state_q == ST_ZERO));
    end
endmodule

// File: rtl/pec_sticky.sv
module pec_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    always_ff @(posedge clk) begin
        if (!rst_n)     q_o <= 1'b0;
        else if (set_i) q_o <= 1'b1;
        else if (clr_i) q_o <= 1'b0;
    end
endmodule

// File: rtl/perf_evt_counter.sv
module perf_evt_counter
    import pec_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_i,
    input  logic             upd_i,
    input  logic             clr_first_i,
    input  logic             clr_evt_i,
    output logic [CNT_W-1:0] hold_o,
    output logic [CNT_W-1:0] live_o,
    output logic             nonzero_o,
    output logic             first_latch_o,
    output logic             evt_latch_o
);
    logic                 upd_pulse;
    logic                 first_evt;
    logic [NUM_FLAGS-1:0] flag_set, flag_clr, flag_q;
    logic [CNT_W-1:0]     hold_q;

    pec_upd_edge u_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .upd_i       (upd_i),
        .upd_pulse_o (upd_pulse)
    );

    pec_count_core #(.CNT_W(CNT_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt_i),
        .upd_pulse_i (upd_pulse),
        .live_o      (live_o),
        .nonzero_o   (nonzero_o),
        .first_evt_o (first_evt)
    );

    assign flag_set[FLAG_FIRST] = first_evt;
    assign flag_set[FLAG_EVT]   = evt_i;
    assign flag_clr[FLAG_FIRST] = clr_first_i;
    assign flag_clr[FLAG_EVT]   = clr_evt_i;

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        pec_sticky u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (flag_set[g]),
            .clr_i (flag_clr[g]),
            .q_o   (flag_q[g])
        );
    end

    assign first_latch_o = flag_q[FLAG_FIRST];
    assign evt_latch_o   = flag_q[FLAG_EVT];

    // holding register: loads only on an update-clear
    always_ff @(posedge clk) begin
        if (!rst_n)         hold_q <= '0;
        else if (upd_pulse) hold_q <= live_o;
    end
    assign hold_o = hold_q;
endmodule

// File: rtl/pec_checker.sv
module pec_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             evt_i,
    input logic             upd_pulse,
    input logic             clr_first_i,
    input logic             clr_evt_i,
    input logic [CNT_W-1:0] hold_o,
    input logic [CNT_W-1:0] live_o,
    input logic             nonzero_o,
    input logic             first_latch_o,
    input logic             evt_latch_o
);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (live_o == CMAX && evt_i && !upd_pulse) |=> (live_o == CMAX));

    assert_step_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (live_o != CMAX && evt_i && !upd_pulse) |=> (live_o == $past(live_o) + CNT_W'(1)));

    assert_nonzero_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        nonzero_o == (live_o != '0));

    assert_first_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i && (live_o == '0 || upd_pulse)) |=> first_latch_o);

    assert_evt_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i |=> evt_latch_o);

    assert_hold_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pulse |=> (hold_o == $past(live_o)));

    assert_restart_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_pulse && evt_i) |=> (live_o == CNT_W'(1)));

    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_pulse |=> $stable(hold_o));

    assert_first_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_first_i && !evt_i) |=> !first_latch_o);

    assert_evt_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_evt_i && !evt_i) |=> !evt_latch_o);
endmodule

bind perf_evt_counter pec_checker #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .evt_i         (evt_i),
    .upd_pulse     (upd_pulse),
    .clr_first_i   (clr_first_i),
    .clr_evt_i     (clr_evt_i),
    .hold_o        (hold_o),
    .live_o        (live_o),
    .nonzero_o     (nonzero_o),
    .first_latch_o (first_latch_o),
    .evt_latch_o   (evt_latch_o)
);

// File: tb/tb_perf_evt_counter.sv
module tb_perf_evt_counter;
    localparam int W = 4;
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic evt = 1'b0, upd = 1'b0, clr_f = 1'b0, clr_e = 1'b0;
    logic [W-1:0] hold, live;
    logic nz, fl, el;
    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    perf_evt_counter #(.CNT_W(W)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .evt_i         (evt),
        .upd_i         (upd),
        .clr_first_i   (clr_f),
        .clr_evt_i     (clr_e),
        .hold_o        (hold),
        .live_o        (live),
        .nonzero_o     (nz),
        .first_latch_o (fl),
        .evt_latch_o   (el)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // entered at a negedge; apply inputs, pass one posedge, return at next negedge
    task automatic cyc(input logic e, input logic u, input logic cf, input logic ce);
        evt = e; upd = u; clr_f = cf; clr_e = ce;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R8 hold after reset", int'(hold), 0);
        check("R8 live after reset", int'(live), 0);
        check("R3 nonzero after reset", int'(nz), 0);
        check("R8 first flag after reset", int'(fl), 0);
        check("R8 event flag after reset", int'(el), 0);
    endtask

    task automatic t_count();
        for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0);
        check("R2 five events", int'(live), 5);
        check("R3 nonzero high", int'(nz), 1);
        check("R4 first flag set", int'(fl), 1);
        check("R5 event flag set", int'(el), 1);
        cyc(0, 0, 0, 0);
        cyc(0, 0, 0, 0);
        check("R2 idle keeps count", int'(live), 5);
    endtask

    task automatic t_clear();
        cyc(0, 0, 1, 1);
        check("R9 first flag cleared", int'(fl), 0);
        check("R9 event flag cleared", int'(el), 0);
        cyc(1, 0, 0, 1);
        check("R9 set beats clear", int'(el), 1);
        check("R4 no first flag from nonzero count", int'(fl), 0);
        check("R2 count after event", int'(live), 6);
    endtask

    task automatic t_update_level();
        cyc(0, 1, 0, 0);
        check("R6 hold loaded", int'(hold), 6);
        check("R6 live cleared", int'(live), 0);
        check("R3 nonzero low after clear", int'(nz), 0);
        cyc(1, 1, 0, 0);
        cyc(1, 1, 0, 0);
        cyc(0, 1, 0, 0);
        check("R6 held level no second transfer", int'(hold), 6);
        check("R6 counting while held", int'(live), 2);
        cyc(0, 0, 0, 0);
        check("R8 hold retained", int'(hold), 6);
    endtask

    task automatic t_update_evt();
        cyc(1, 0, 1, 0);
        cyc(0, 0, 1, 0);
        check("R9 first flag cleared again", int'(fl), 0);
        cyc(1, 1, 0, 0);
        check("R7 restart at one", int'(live), 1);
        check("R6 hold with concurrent event", int'(hold), 3);
        check("R4 first flag on update event", int'(fl), 1);
        cyc(0, 0, 0, 0);
    endtask

    task automatic t_saturate();
        for (int i = 0; i < 20; i++) cyc(1, 0, 0, 0);
        check("R1 saturated", int'(live), int'(TOP));
        cyc(0, 0, 0, 1);
        check("R9 event flag clear at full", int'(el), 0);
        cyc(1, 0, 0, 0);
        check("R1 stays at max", int'(live), int'(TOP));
        check("R5 event flag at saturation", int'(el), 1);
        cyc(0, 1, 0, 0);
        check("R6 hold captures max", int'(hold), int'(TOP));
        check("R6 live zero after capture", int'(live), 0);
        cyc(0, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_count();
        t_clear();
        t_update_level();
        t_update_evt();
        t_saturate();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 5000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule